// File: doc/BRIEF.md
# Handshake Channel Protocol Monitor

A passive, synthesizable observer placed beside a link that is built from five valid/ready channels: write address, write data, write response, read address and read data. It drives nothing onto the link. It samples each channel's valid, ready and payload on every clock edge and sets a sticky error bit whenever the traffic breaks one of the handshake rules. A single combined flag tells the surrounding logic that some rule has failed.

For every channel the same back-pressure rules are enforced. A beat is accepted in any cycle where valid and ready are both high. Once a sender raises valid, it must hold valid and the payload unchanged until a beat is accepted. A receiver may lower ready only after a cycle in which valid was high. A stall, meaning valid high with ready low, may not last as long as the configured limit. On the read side the monitor also counts read requests that have not yet been answered, and it flags any read response that arrives while none is outstanding.

Top module: `hs_link_monitor`

## Requirements
- R1: While rst_n is low, and after it is released with no violating traffic, every bit of rule_err, pair_err and any_err is 0.
- R2: If valid is low in a cycle that follows a cycle with valid high and ready low, bit ch*4+0 of rule_err is set at the clock edge that samples the low valid.
- R3: If ready is low in a cycle that follows a cycle with ready high and valid low, bit ch*4+1 of rule_err is set.
- R4: If the payload differs from its value in the previous cycle, and that previous cycle had valid high and ready low, bit ch*4+2 of rule_err is set.
- R5: A run of consecutive stalled cycles (valid high, ready low) sets bit ch*4+3 of rule_err when the run reaches STALL_LIMIT cycles. A shorter run that ends in an accepted beat sets nothing.
- R6: Every error bit, once set, stays set until rst_n is low, whatever traffic follows.
- R7: any_err is the OR of all rule_err bits and pair_err.
- R8: Channel 3 is read address and channel 4 is read data. An accepted beat on channel 4 while no channel-3 beat is outstanding sets pair_err. A channel-3 beat in the same cycle does not count as outstanding.
- R9: The outstanding read count saturates at MAX_OUTSTANDING. Requests beyond that limit are not counted, so the (MAX_OUTSTANDING+1)-th response after a burst of more requests sets pair_err.
- R10: In the first clock cycle after rst_n rises, the rules that compare against the previous cycle (R2, R3, R4) are not applied.
- R11: Channel ch occupies ch_valid[ch], ch_ready[ch] and ch_payload[ch*DATA_W +: DATA_W]. Channels 0 to 4 are write address, write data, write response, read address and read data.
- R12: Legal traffic raises no flag. This includes accepted beats, stalls shorter than the limit with a steady payload, and ready dropping after a cycle with valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all flags |
| ch_valid | input | 5 | Valid of each channel |
| ch_ready | input | 5 | Ready of each channel |
| ch_payload | input | 5*DATA_W | Payload of each channel, packed by channel index |
| rule_err | output | 20 | Sticky rule flags; bit ch*4+r, with r = 0 valid drop, 1 ready drop, 2 payload change, 3 stall limit |
| pair_err | output | 1 | Sticky flag for a read response with no outstanding request |
| any_err | output | 1 | OR of all flags |

## Verification
The case hardest to reach from the ports is the saturation of the outstanding read counter. It needs more read-address beats than the counter can hold, followed by exactly one response more than the limit. The bench sweeps every combination of request count and response count up to one past the limit, and it compares pair_err against the arithmetic rule that the responses exceed the smaller of the request count and the limit. The stall limit gets a similar sweep of run lengths on every channel, one cycle either side of the threshold.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int NUM_CH    = 5;
  localparam int NUM_RULES = 4;
  // rule bit positions inside a channel's flag group
  localparam int RULE_VDROP = 0;
  localparam int RULE_RDROP = 1;
  localparam int RULE_HOLD  = 2;
  localparam int RULE_STALL = 3;
  // channel roles used by the read pairing tracker
  localparam int CH_RD_REQ = 3;
  localparam int CH_RD_RSP = 4;
  typedef logic [NUM_RULES-1:0] rule_vec_t;
endpackage

// File: rtl/hs_chan_checker.sv
module hs_chan_checker
  import hs_mon_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int STALL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              ready,
  input  logic [DATA_W-1:0] payload,
  output rule_vec_t         err
);
  localparam int CNT_W = $clog2(STALL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(STALL_LIMIT);
  localparam logic [CNT_W-1:0] CNT_TRIP = CNT_W'(STALL_LIMIT - 1);

  logic              prev_valid, prev_ready;
  logic [DATA_W-1:0] prev_payload;
  logic              armed;
  logic [CNT_W-1:0]  stall_cnt;
  rule_vec_t         err_q, viol;

  // history is kept through reset; armed gates its use
  always_ff @(posedge clk) begin
    prev_valid   <= valid;
    prev_ready   <= ready;
    prev_payload <= payload;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                stall_cnt <= '0;
    else if (valid && !ready)  stall_cnt <= (stall_cnt == CNT_MAX) ? CNT_MAX : stall_cnt + 1'b1;
    else                       stall_cnt <= '0;
  end

  always_comb begin
    viol = '0;
    if (armed) begin
      viol[RULE_VDROP] = prev_valid && !prev_ready && !valid;
      viol[RULE_RDROP] = prev_ready && !prev_valid && !ready;
      viol[RULE_HOLD]  = prev_valid && !prev_ready && (payload != prev_payload);
    end
    viol[RULE_STALL] = valid && !ready && (stall_cnt == CNT_TRIP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_q | viol;
  end

  assign err = err_q;

  // R2
  vdrop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(valid) && !$past(ready) && !valid) |=> err_q[RULE_VDROP]);
  // R3
  rdrop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ready) && !$past(valid) && !ready) |=> err_q[RULE_RDROP]);
  // R4
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(valid) && !$past(ready) && $changed(payload)) |=> err_q[RULE_HOLD]);
  // R5
  stall_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt == CNT_MAX) |-> err_q[RULE_STALL]);
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/hs_read_pairing.sv
module hs_read_pairing #(
  parameter int MAX_OUTSTANDING = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_xfer,
  input  logic rsp_xfer,
  output logic err
);
  localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1);
  localparam logic [CNT_W:0] CNT_MAX = (CNT_W+1)'(MAX_OUTSTANDING);

  logic [CNT_W-1:0] pend;
  logic [CNT_W:0]   pend_sum;
  logic             orphan, take;
  logic             err_q;

  assign orphan   = rsp_xfer && (pend == '0);
  assign take     = rsp_xfer && (pend != '0);
  assign pend_sum = {1'b0, pend} + {{CNT_W{1'b0}}, req_xfer} - {{CNT_W{1'b0}}, take};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      err_q <= 1'b0;
    end else begin
      pend  <= (pend_sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : pend_sum[CNT_W-1:0];
      err_q <= err_q | orphan;
    end
  end

  assign err = err_q;

  // R8
  orphan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_xfer && pend == '0) |=> err_q);
  // R9
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pend} <= CNT_MAX));
  // R6
  pair_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor
  import hs_mon_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int STALL_LIMIT     = 16,
  parameter int MAX_OUTSTANDING = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0]              ch_valid,
  input  logic [NUM_CH-1:0]              ch_ready,
  input  logic [NUM_CH*DATA_W-1:0]       ch_payload,
  output logic [NUM_CH*NUM_RULES-1:0]    rule_err,
  output logic                           pair_err,
  output logic                           any_err
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    hs_chan_checker #(
      .DATA_W      (DATA_W),
      .STALL_LIMIT (STALL_LIMIT)
    ) u_chk (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (ch_valid[ch]),
      .ready   (ch_ready[ch]),
      .payload (ch_payload[ch*DATA_W +: DATA_W]),
      .err     (rule_err[ch*NUM_RULES +: NUM_RULES])
    );
  end

  hs_read_pairing #(
    .MAX_OUTSTANDING (MAX_OUTSTANDING)
  ) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_xfer (ch_valid[CH_RD_REQ] && ch_ready[CH_RD_REQ]),
    .rsp_xfer (ch_valid[CH_RD_RSP] && ch_ready[CH_RD_RSP]),
    .err      (pair_err)
  );

  assign any_err = (|rule_err) | pair_err;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (!any_err && rule_err == '0));
endmodule

// File: tb/hs_link_monitor_bench.sv
module hs_link_monitor_bench;
  localparam int DW  = 8;
  localparam int LIM = 4;
  localparam int MO  = 3;
  localparam int NC  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC-1:0]   valid = '0;
  logic [NC-1:0]   ready = '0;
  logic [NC*DW-1:0] payload = '0;
  logic [NC*4-1:0] rule_err;
  logic            pair_err, any_err;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hs_link_monitor #(.DATA_W(DW), .STALL_LIMIT(LIM), .MAX_OUTSTANDING(MO)) u_hs_link_monitor (
    .clk(clk), .rst_n(rst_n), .ch_valid(valid), .ch_ready(ready),
    .ch_payload(payload), .rule_err(rule_err), .pair_err(pair_err), .any_err(any_err));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_vec(input logic [NC*4-1:0] got, input logic [NC*4-1:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_bit(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = '0; ready = '0; payload = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic xfer(input int c, input logic [DW-1:0] d);
    valid[c] = 1'b1; ready[c] = 1'b1; payload[c*DW +: DW] = d;
    step();
    valid[c] = 1'b0; ready[c] = 1'b0;
    step();
  endtask

  function automatic logic [NC*4-1:0] bitv(input int c, input int r);
    return (NC*4)'(1) << (c*4 + r);
  endfunction

  initial begin
    // R1 reset state
    rst_n = 1'b0; valid = '1; ready = '0; payload = '1;
    repeat (3) step();
    chk_vec(rule_err, '0, "R1 flags in reset");
    chk_bit(pair_err | any_err, 1'b0, "R1 pair/any in reset");

    // R10 valid high in reset, low in first cycle after release
    rst_n = 1'b1; valid = '0; payload = '0;
    step(); step();
    chk_vec(rule_err, '0, "R10 no check in first cycle after reset");
    chk_bit(any_err, 1'b0, "R10 any_err quiet");

    for (int c = 0; c < NC; c++) begin
      // R12 legal traffic: short stall, steady payload, ready-first accept
      do_reset();
      valid[c] = 1'b1; payload[c*DW +: DW] = 8'hA5;
      step(); step();
      ready[c] = 1'b1; step();
      payload[c*DW +: DW] = 8'h3C; step();
      valid[c] = 1'b0; ready[c] = 1'b0; step();
      ready[c] = 1'b1; step();
      valid[c] = 1'b1; step();
      valid[c] = 1'b0; ready[c] = 1'b0; step();
      chk_vec(rule_err, '0, $sformatf("R12 legal traffic ch%0d", c));

      // R2 valid withdrawn while stalled
      do_reset();
      valid[c] = 1'b1; step();
      valid[c] = 1'b0; step();
      chk_vec(rule_err, bitv(c, 0), $sformatf("R2 R11 valid drop ch%0d", c));
      chk_bit(any_err, 1'b1, $sformatf("R7 any_err ch%0d", c));
      // R6 sticky through legal traffic
      xfer(c, 8'h11); xfer(c, 8'h22);
      chk_vec(rule_err, bitv(c, 0), $sformatf("R6 sticky ch%0d", c));

      // R3 ready withdrawn with no valid
      do_reset();
      ready[c] = 1'b1; step();
      ready[c] = 1'b0; step();
      chk_vec(rule_err, bitv(c, 1), $sformatf("R3 R11 ready drop ch%0d", c));

      // R4 payload changed during stall
      do_reset();
      valid[c] = 1'b1; payload[c*DW +: DW] = 8'h5A; step();
      payload[c*DW +: DW] = 8'h5B; step();
      ready[c] = 1'b1; step();
      valid[c] = 1'b0; ready[c] = 1'b0; step();
      chk_vec(rule_err, bitv(c, 2), $sformatf("R4 R11 payload change ch%0d", c));

      // R5 stall length sweep
      for (int len = 1; len <= LIM + 1; len++) begin
        do_reset();
        valid[c] = 1'b1;
        for (int k = 0; k < len; k++) step();
        ready[c] = 1'b1; step();
        valid[c] = 1'b0; ready[c] = 1'b0; step();
        chk_vec(rule_err, (len >= LIM) ? bitv(c, 3) : '0,
                $sformatf("R5 stall len %0d ch%0d", len, c));
      end
    end

    // R8 R9 request/response sweep
    for (int n = 0; n <= MO + 1; n++) begin
      for (int k = 0; k <= MO + 1; k++) begin
        do_reset();
        for (int i = 0; i < n; i++) xfer(3, 8'(i));
        for (int i = 0; i < k; i++) xfer(4, 8'(i));
        chk_bit(pair_err, (k > ((n < MO) ? n : MO)) ? 1'b1 : 1'b0,
                $sformatf("R8 R9 req %0d rsp %0d", n, k));
        chk_vec(rule_err, '0, $sformatf("R12 pairing traffic req %0d rsp %0d", n, k));
      end
    end

    // R8 same-cycle request and response with none outstanding
    do_reset();
    valid[3] = 1'b1; ready[3] = 1'b1; valid[4] = 1'b1; ready[4] = 1'b1;
    step();
    valid = '0; ready = '0; step();
    chk_bit(pair_err, 1'b1, "R8 same-cycle response is orphan");
    chk_bit(any_err, 1'b1, "R7 any_err from pair_err");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule